// File: doc/BRIEF.md
# Operate Unit with Condition Flags

This block executes the register-to-register operations of a 16-bit processor: addition, bitwise AND and bitwise complement. It takes the instruction word and two source operands read from the register file elsewhere, decodes which operation is meant, and selects the second operand. That operand is either the second source register or a 5-bit constant carried in the instruction and sign-extended to the data width. The result is presented one clock later, together with a flag that says whether the instruction was an operate instruction.

Separately, the block keeps a three-bit condition register with negative, zero and positive flags. Exactly one of the three is set at any time. When the control sequencer asserts the flag-load strobe, the register captures the class of the value on the shared data bus. The flags feed the branch-decision logic. The sequencer raises the strobe for every instruction that writes a general register, so the flags do not have to come from this unit's own result.

Top module: `operate_unit`

## Requirements
- R1: The operation comes from `instr[15:12]`: 4'b0001 is add, 4'b0101 is and, 4'b1001 is complement. `result` and `result_valid` reflect the instruction presented one clock edge earlier.
- R2: Add with `instr[5]` = 0 (register mode) gives `result = src_a + src_b` modulo 2^16, with `result_valid` = 1.
- R3: With `instr[5]` = 1 (immediate mode), the second operand of add and of and is `instr[4:0]` sign-extended to 16 bits, and `src_b` is ignored.
- R4: And gives `result = src_a & operand2`, where operand2 is chosen as in R2/R3, with `result_valid` = 1.
- R5: Complement needs `instr[5:0]` = 6'b111111 and gives `result = ~src_a`. `src_b` has no effect on it.
- R6: Any other opcode, and a complement whose low six bits are not all ones, gives `result` = 0 and `result_valid` = 0 on the next clock.
- R7: While `rst` is high at a clock edge, `result` becomes 0, `result_valid` becomes 0 and the flags become N=0, Z=1, P=0.
- R8: When `cc_load` is 1 at an edge, the flags become N=1 if `cc_bus[15]` is 1, else Z=1 if `cc_bus` is 0, else P=1. The other two flags are 0.
- R9: When `cc_load` is 0, the flags keep their value whatever `instr`, the operands or `cc_bus` do.
- R10: Exactly one of `flag_n`, `flag_z`, `flag_p` is 1 in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 16 | Instruction word |
| src_a | input | 16 | First source register value |
| src_b | input | 16 | Second source register value |
| cc_load | input | 1 | Flag-load strobe from the sequencer |
| cc_bus | input | 16 | Shared bus value classified into flags |
| result | output | 16 | Registered operation result |
| result_valid | output | 1 | Registered: previous instruction was a recognised operate instruction |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_p | output | 1 | Positive flag |

## Verification
The hardest situations to reach are the flag boundaries and the flag-hold behaviour. A bus value of 0x8000 must read as negative and 0x7FFF as positive. The flags must stay put while operate instructions with zero or negative results run and the strobe is low. The stimulus therefore loads the flags at each sign and zero boundary. It then runs operations whose results would have changed the flags had they been latched, with the bus driven to zero. Immediate-mode edges (-16, -1, +15) and a complement instruction with one wrong tail bit exercise decoding that random opcodes would rarely hit.

// File: rtl/opu_pkg.sv
package opu_pkg;
  localparam int OPC_W = 4;
  localparam logic [OPC_W-1:0] OPC_ADD = 4'b0001;
  localparam logic [OPC_W-1:0] OPC_AND = 4'b0101;
  localparam logic [OPC_W-1:0] OPC_NOT = 4'b1001;

  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_ADD  = 2'd1,
    K_AND  = 2'd2,
    K_NOT  = 2'd3
  } alu_kind_e;

  typedef struct packed {
    logic n;
    logic z;
    logic p;
  } cc_t;
endpackage

// File: rtl/opu_decode.sv
module opu_decode
  import opu_pkg::*;
#(
  parameter int INSN_W   = 16,
  parameter int MODE_BIT = 5,
  parameter int IMM_W    = 5
) (
  input  logic [INSN_W-1:0] instr,
  output alu_kind_e         kind,
  output logic              imm_mode,
  output logic [IMM_W-1:0]  imm_field
);
  localparam int OPC_LSB = INSN_W - OPC_W;

  logic [OPC_W-1:0] opc;
  logic             not_tail_ok;
  logic             unused_reg_fields;

  assign opc               = instr[INSN_W-1:OPC_LSB];
  assign not_tail_ok       = &instr[MODE_BIT:0];
  assign imm_mode          = instr[MODE_BIT];
  assign imm_field         = instr[IMM_W-1:0];
  // register specifiers are consumed by the register file, not here
  assign unused_reg_fields = ^instr[OPC_LSB-1:MODE_BIT+1];

  always_comb begin
    case (opc)
      OPC_ADD: kind = K_ADD;
      OPC_AND: kind = K_AND;
      OPC_NOT: kind = not_tail_ok ? K_NOT : K_NONE;
      default: kind = K_NONE;
    endcase
  end
endmodule

// File: rtl/opu_operand.sv
module opu_operand #(
  parameter int DATA_W = 16,
  parameter int IMM_W  = 5
) (
  input  logic [DATA_W-1:0] src_b,
  input  logic              imm_mode,
  input  logic [IMM_W-1:0]  imm_field,
  output logic [DATA_W-1:0] opnd_b
);
  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_ext;

  generate
    if (EXT_W > 0) begin : g_ext
      assign imm_ext = {{EXT_W{imm_field[IMM_W-1]}}, imm_field};
    end else begin : g_noext
      assign imm_ext = imm_field[DATA_W-1:0];
    end
  endgenerate

  assign opnd_b = imm_mode ? imm_ext : src_b;
endmodule

// File: rtl/opu_alu.sv
module opu_alu
  import opu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  alu_kind_e         kind,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic [DATA_W-1:0] res_q,
  output logic              vld_q
);
  logic [DATA_W-1:0] res_d;

  always_comb begin
    case (kind)
      K_ADD:   res_d = opnd_a + opnd_b;
      K_AND:   res_d = opnd_a & opnd_b;
      K_NOT:   res_d = ~opnd_a;
      default: res_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      res_q <= res_d;
      vld_q <= (kind != K_NONE);
    end
  end

  a_r2_add_sum: assert property (@(posedge clk) disable iff (rst)
    (kind == K_ADD) |=> (res_q == DATA_W'($past(opnd_a) + $past(opnd_b))) && vld_q);
  a_r5_not_inv: assert property (@(posedge clk) disable iff (rst)
    (kind == K_NOT) |=> (res_q == ~$past(opnd_a)) && vld_q);
  a_r6_none_zero: assert property (@(posedge clk) disable iff (rst)
    (kind == K_NONE) |=> (res_q == '0) && !vld_q);
endmodule

// File: rtl/opu_ccr.sv
module opu_ccr
  import opu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] bus,
  output cc_t               flags_q
);
  cc_t flags_d;

  always_comb begin
    flags_d.n = bus[DATA_W-1];
    flags_d.z = (bus == '0);
    flags_d.p = !bus[DATA_W-1] && (bus != '0);
  end

  always_ff @(posedge clk) begin
    if (rst)       flags_q <= '{n: 1'b0, z: 1'b1, p: 1'b0};
    else if (load) flags_q <= flags_d;
  end

  a_r10_onehot: assert property (@(posedge clk) disable iff (rst)
    $countones(flags_q) == 1);
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(flags_q));
  a_r8_neg: assert property (@(posedge clk) disable iff (rst)
    (load && bus[DATA_W-1]) |=> flags_q.n);
  a_r8_zero: assert property (@(posedge clk) disable iff (rst)
    (load && bus == '0) |=> flags_q.z);
endmodule

// File: rtl/operate_unit.sv
module operate_unit
  import opu_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int IMM_W    = 5,
  parameter int MODE_BIT = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] instr,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic              cc_load,
  input  logic [DATA_W-1:0] cc_bus,
  output logic [DATA_W-1:0] result,
  output logic              result_valid,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_p
);
  alu_kind_e         kind;
  logic              imm_mode;
  logic [IMM_W-1:0]  imm_field;
  logic [DATA_W-1:0] opnd_b;
  cc_t               flags;

  opu_decode #(.INSN_W(DATA_W), .MODE_BIT(MODE_BIT), .IMM_W(IMM_W)) u_dec (
    .instr(instr), .kind(kind), .imm_mode(imm_mode), .imm_field(imm_field)
  );

  opu_operand #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opnd (
    .src_b(src_b), .imm_mode(imm_mode), .imm_field(imm_field), .opnd_b(opnd_b)
  );

  opu_alu #(.DATA_W(DATA_W)) u_alu (
    .clk(clk), .rst(rst), .kind(kind), .opnd_a(src_a), .opnd_b(opnd_b),
    .res_q(result), .vld_q(result_valid)
  );

  opu_ccr #(.DATA_W(DATA_W)) u_ccr (
    .clk(clk), .rst(rst), .load(cc_load), .bus(cc_bus), .flags_q(flags)
  );

  assign flag_n = flags.n;
  assign flag_z = flags.z;
  assign flag_p = flags.p;

  a_r7_reset_out: assert property (@(posedge clk)
    rst |=> (result == '0) && !result_valid && flag_z && !flag_n && !flag_p);
endmodule

// File: tb/operate_unit_bench.sv
`timescale 1ns/1ps
module operate_unit_bench;
  localparam int NV = 14;
  // {instr, src_a, src_b, expected result, expected valid}
  localparam logic [64:0] VEC [NV] = '{
    {16'h1042, 16'h1234, 16'h0111, 16'h1345, 1'b1}, // R2 add reg
    {16'h1042, 16'hFFFF, 16'h0001, 16'h0000, 1'b1}, // R2 wrap
    {16'h107F, 16'h0010, 16'hAAAA, 16'h000F, 1'b1}, // R3 imm -1
    {16'h106F, 16'h0100, 16'h5555, 16'h010F, 1'b1}, // R3 imm +15
    {16'h1070, 16'h0000, 16'h0001, 16'hFFF0, 1'b1}, // R3 imm -16
    {16'h5042, 16'hF0F0, 16'h3C3C, 16'h3030, 1'b1}, // R4 and reg
    {16'h5066, 16'hFFFF, 16'h0000, 16'h0006, 1'b1}, // R4 and imm
    {16'h507E, 16'h1235, 16'h0000, 16'h1234, 1'b1}, // R4 and imm -2
    {16'h907F, 16'h00FF, 16'h1234, 16'hFF00, 1'b1}, // R5 not
    {16'h907F, 16'h0000, 16'hFFFF, 16'hFFFF, 1'b1}, // R5 not, other src_b
    {16'h907E, 16'h00FF, 16'h0000, 16'h0000, 1'b0}, // R6 bad not tail
    {16'h0E05, 16'h1111, 16'h2222, 16'h0000, 1'b0}, // R6 branch opcode
    {16'hD000, 16'h1111, 16'h2222, 16'h0000, 1'b0}, // R6 reserved
    {16'h2042, 16'h1111, 16'h2222, 16'h0000, 1'b0}  // R6 load opcode
  };
  localparam logic [3:0] VREQ [NV] = '{2,2,3,3,3,4,4,4,5,5,6,6,6,6};

  logic clk = 1'b0, rst = 1'b1, cc_load = 1'b0;
  logic [15:0] instr = '0, src_a = '0, src_b = '0, cc_bus = '0;
  logic [15:0] result;
  logic result_valid, flag_n, flag_z, flag_p;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  operate_unit u_operate_unit (
    .clk(clk), .rst(rst), .instr(instr), .src_a(src_a), .src_b(src_b),
    .cc_load(cc_load), .cc_bus(cc_bus), .result(result),
    .result_valid(result_valid), .flag_n(flag_n), .flag_z(flag_z), .flag_p(flag_p)
  );

  function automatic string req_name(input logic [3:0] r);
    case (r)
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_flags(input string tag, input logic [2:0] exp_nzp);
    chk(tag, {29'd0, flag_n, flag_z, flag_p}, {29'd0, exp_nzp});
    chk("R10 onehot", {31'd0, (flag_n + flag_z + flag_p) == 2'd1}, 32'd1);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R7 reset state
    step(); step();
    chk("R7 result", {16'd0, result}, 32'd0);
    chk("R7 valid", {31'd0, result_valid}, 32'd0);
    chk_flags("R7 flags", 3'b010);
    rst = 1'b0;
    step();

    // R1 R2 R3 R4 R5 R6 vector table
    for (int i = 0; i < NV; i++) begin
      instr = VEC[i][64:49];
      src_a = VEC[i][48:33];
      src_b = VEC[i][32:17];
      step();
      chk({req_name(VREQ[i]), " result"}, {16'd0, result}, {16'd0, VEC[i][16:1]});
      chk({req_name(VREQ[i]), " R1 valid"}, {31'd0, result_valid}, {31'd0, VEC[i][0]});
    end
    chk_flags("R9 flags untouched by ops", 3'b010);

    // R8 flag classification at boundaries
    cc_load = 1'b1;
    cc_bus = 16'h8000; step(); chk_flags("R8 0x8000", 3'b100);
    cc_bus = 16'h7FFF; step(); chk_flags("R8 0x7FFF", 3'b001);
    cc_bus = 16'h0000; step(); chk_flags("R8 zero", 3'b010);
    cc_bus = 16'hFFFF; step(); chk_flags("R8 0xFFFF", 3'b100);
    cc_bus = 16'h0001; step(); chk_flags("R8 one", 3'b001);

    // R9 hold: strobe low, bus zero, op result zero
    cc_load = 1'b0;
    cc_bus = 16'h0000;
    instr = 16'h1042; src_a = 16'hFFFF; src_b = 16'h0001;
    step();
    chk("R2 wrap during hold", {16'd0, result}, 32'd0);
    chk_flags("R9 hold positive", 3'b001);
    cc_bus = 16'h8000;
    instr = 16'h907F; src_a = 16'h0000;
    step(); step();
    chk_flags("R9 hold after negative bus", 3'b001);

    // R1 valid drops back after a good op
    instr = 16'hF025;
    step();
    chk("R1 valid after illegal", {31'd0, result_valid}, 32'd0);

    // R7 reset mid-run
    cc_load = 1'b1; cc_bus = 16'h8000; instr = 16'h1042;
    step();
    rst = 1'b1; cc_load = 1'b0;
    step();
    chk_flags("R7 reset flags", 3'b010);
    chk("R7 reset valid", {31'd0, result_valid}, 32'd0);
    rst = 1'b0;
    step();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule